// File: doc/BRIEF.md
# Store-Set Dependence Predictor with Strict Waiting

This block predicts which older stores a load must wait for in an out-of-order core. Each instruction address is hashed into an identifier table. Loads and stores that have collided in the past share a set number in that table. A second table, indexed by set number, records the store-queue slot of the most recently dispatched store of each set. When a load asks which store it depends on, it normally receives that one slot as a one-hot mask.

Training comes from memory-order violations. Each violation reports the address of the offending load and the address of the store it overtook. A load that violates again inside a set it already belongs to is marked strict. While the strict feature is enabled, a strict load waits on every store that has dispatched and not yet issued. A bit vector over store-queue slots tracks those outstanding stores. A clear pulse returns the whole predictor to its empty state.

Top module: `ssp_predictor`

## Requirements
- R1: After reset, every table entry is invalid, no store is pending and `depValid` is low with `depMask` zero and `depStrict` low.
- R2: A lookup presented in one cycle yields `depValid`, `depStrict` and `depMask` after the next rising edge. The result uses the state before any update made in that same cycle. Without a lookup, `depValid` is low and the other two outputs are zero.
- R3: Tables are indexed by PC bits [7:2]. If neither the load nor the store of a violation has a valid entry, both receive a fresh set number equal to the load's PC bits [5:2], and the load's strict bit is cleared.
- R4: If exactly one of the two has a valid entry, the other takes that set number. A load that gains a number this way has its strict bit cleared. A load whose store joins its set keeps its strict bit.
- R5: If both have valid entries, the one holding the larger set number takes the smaller number. On equal numbers the load is rewritten with its own number and its strict bit is set. A load that takes a different, smaller number gets its strict bit cleared.
- R6: Every dispatched store sets its slot bit in the pending vector. If the store's entry is valid, the last-store record of its set takes the store's slot.
- R7: An issuing store clears its pending bit and invalidates any last-store record that holds its slot. A dispatch and an issue of different slots in the same cycle both take effect.
- R8: A non-strict lookup returns the one-hot slot of its set's last store, or zero if the entry or the record is invalid. `depStrict` is low in this case.
- R9: If `strictEnable` is high and the load's entry is valid and strict, the lookup returns the whole pending vector with `depStrict` high. With `strictEnable` low, the same load is treated as in R8.
- R10: A clear pulse invalidates all entries, clears all strict bits and empties the pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strictEnable | input | 1 | Enables strict waiting (normally tied high) |
| clearReq | input | 1 | Empties the whole predictor |
| trainValid | input | 1 | A violation is being reported |
| trainLoadPc | input | PC_W | Address of the violating load |
| trainStorePc | input | PC_W | Address of the overtaken store |
| dispValid | input | 1 | A store dispatches |
| dispPc | input | PC_W | Address of the dispatching store |
| dispSlot | input | SLOT_W | Store-queue slot of the dispatching store |
| issueValid | input | 1 | A store issues |
| issueSlot | input | SLOT_W | Store-queue slot of the issuing store |
| lookupValid | input | 1 | A load requests its dependence |
| lookupPc | input | PC_W | Address of the load |
| depValid | output | 1 | Lookup result is present |
| depStrict | output | 1 | Result is the full pending vector |
| depMask | output | SQ_SLOTS | Slots the load must wait for |

## Verification
Table updates caused by training, dispatch, issue and clear take effect at the rising edge that samples them. A lookup result appears at that same edge and is therefore visible one cycle after the lookup was driven. The bench drives every input on a falling edge and then waits through exactly one rising edge. It compares the outputs on the following falling edge. With this timing, a lookup paired with an update in one vector must return the old state, and the next vector's lookup must see the new state. The expected masks in the vector table are written to that rule.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Source of the set number written during training.
  typedef enum logic [1:0] {
    ID_FRESH      = 2'd0,
    ID_FROM_LOAD  = 2'd1,
    ID_FROM_STORE = 2'd2
  } idSel_e;

  // Strobes from training control to the table datapath.
  typedef struct packed {
    logic   clearAll;
    logic   wrLoad;
    logic   wrStore;
    logic   loadStrict;
    idSel_e idSel;
  } trainStrobe_t;

endpackage

// File: rtl/ssp_train_ctrl.sv
module ssp_train_ctrl
  import ssp_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearReq,
  input  logic              trainValid,
  input  logic              loadHit,
  input  logic              storeHit,
  input  logic [ID_W-1:0]   loadId,
  input  logic [ID_W-1:0]   storeId,
  output trainStrobe_t      strobe
);

  always_comb begin
    strobe = '0;
    strobe.clearAll = clearReq;
    if (!clearReq && trainValid) begin
      unique case ({loadHit, storeHit})
        2'b00: begin
          strobe.wrLoad  = 1'b1;
          strobe.wrStore = 1'b1;
          strobe.idSel   = ID_FRESH;
        end
        2'b10: begin
          strobe.wrStore = 1'b1;
          strobe.idSel   = ID_FROM_LOAD;
        end
        2'b01: begin
          strobe.wrLoad  = 1'b1;
          strobe.idSel   = ID_FROM_STORE;
        end
        default: begin
          if (loadId < storeId) begin
            strobe.wrStore = 1'b1;
            strobe.idSel   = ID_FROM_LOAD;
          end else begin
            strobe.wrLoad     = 1'b1;
            strobe.idSel      = ID_FROM_STORE;
            strobe.loadStrict = (loadId == storeId);
          end
        end
      endcase
    end
  end

  // R5: a strict mark is only produced by a repeat violation within one set
  p_strict_only_on_repeat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrLoad && strobe.loadStrict) |-> (loadHit && storeHit && loadId == storeId));

  // R10: a clear never coincides with a table write
  p_no_write_on_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |-> !(strobe.wrLoad || strobe.wrStore));

endmodule

// File: rtl/ssp_tables.sv
module ssp_tables
  import ssp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SSIT_DEPTH = 64,
  parameter int NUM_SETS   = 16,
  parameter int SQ_SLOTS   = 16,
  localparam int IDX_W     = $clog2(SSIT_DEPTH),
  localparam int ID_W      = $clog2(NUM_SETS),
  localparam int SLOT_W    = $clog2(SQ_SLOTS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strictEnable,
  input  logic                clearReq,
  input  trainStrobe_t        strobe,
  input  logic [PC_W-1:0]     trainLoadPc,
  input  logic [PC_W-1:0]     trainStorePc,
  input  logic                dispValid,
  input  logic [PC_W-1:0]     dispPc,
  input  logic [SLOT_W-1:0]   dispSlot,
  input  logic                issueValid,
  input  logic [SLOT_W-1:0]   issueSlot,
  input  logic                lookupValid,
  input  logic [PC_W-1:0]     lookupPc,
  output logic                loadHit,
  output logic                storeHit,
  output logic [ID_W-1:0]     loadId,
  output logic [ID_W-1:0]     storeId,
  output logic                depValid,
  output logic                depStrict,
  output logic [SQ_SLOTS-1:0] depMask
);

  logic [SSIT_DEPTH-1:0] ssitValid;
  logic [SSIT_DEPTH-1:0] ssitStrict;
  logic [ID_W-1:0]       ssitId [SSIT_DEPTH];
  logic [NUM_SETS-1:0]   lfstValid;
  logic [SLOT_W-1:0]     lfstSlot [NUM_SETS];
  logic [SQ_SLOTS-1:0]   pending;
  logic [SQ_SLOTS-1:0]   pendingNext;

  logic [IDX_W-1:0] trLoadIdx, trStoreIdx, dispIdx, lookIdx;
  assign trLoadIdx  = trainLoadPc[IDX_W+1:2];
  assign trStoreIdx = trainStorePc[IDX_W+1:2];
  assign dispIdx    = dispPc[IDX_W+1:2];
  assign lookIdx    = lookupPc[IDX_W+1:2];

  logic unusedPcBits;
  assign unusedPcBits = ^{trainLoadPc[PC_W-1:IDX_W+2], trainLoadPc[1:0],
                          trainStorePc[PC_W-1:IDX_W+2], trainStorePc[1:0],
                          dispPc[PC_W-1:IDX_W+2], dispPc[1:0],
                          lookupPc[PC_W-1:IDX_W+2], lookupPc[1:0]};

  assign loadHit  = ssitValid[trLoadIdx];
  assign storeHit = ssitValid[trStoreIdx];
  assign loadId   = ssitId[trLoadIdx];
  assign storeId  = ssitId[trStoreIdx];

  logic [ID_W-1:0] chosenId;
  always_comb begin
    unique case (strobe.idSel)
      ID_FROM_LOAD:  chosenId = loadId;
      ID_FROM_STORE: chosenId = storeId;
      default:       chosenId = trLoadIdx[ID_W-1:0];
    endcase
  end

  // Store-set identifier table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssitValid  <= '0;
      ssitStrict <= '0;
      for (int i = 0; i < SSIT_DEPTH; i++) ssitId[i] <= '0;
    end else if (strobe.clearAll) begin
      ssitValid  <= '0;
      ssitStrict <= '0;
      for (int i = 0; i < SSIT_DEPTH; i++) ssitId[i] <= '0;
    end else begin
      if (strobe.wrStore) begin
        ssitValid[trStoreIdx] <= 1'b1;
        ssitId[trStoreIdx]    <= chosenId;
      end
      if (strobe.wrLoad) begin
        ssitValid[trLoadIdx]  <= 1'b1;
        ssitId[trLoadIdx]     <= chosenId;
        ssitStrict[trLoadIdx] <= strobe.loadStrict;
      end
    end
  end

  // Last-fetched-store table
  logic [ID_W-1:0] dispId;
  assign dispId = ssitId[dispIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfstValid <= '0;
      for (int e = 0; e < NUM_SETS; e++) lfstSlot[e] <= '0;
    end else if (clearReq) begin
      lfstValid <= '0;
      for (int e = 0; e < NUM_SETS; e++) lfstSlot[e] <= '0;
    end else begin
      for (int e = 0; e < NUM_SETS; e++) begin
        if (issueValid && lfstValid[e] && lfstSlot[e] == issueSlot)
          lfstValid[e] <= 1'b0;
      end
      if (dispValid && ssitValid[dispIdx]) begin
        lfstValid[dispId] <= 1'b1;
        lfstSlot[dispId]  <= dispSlot;
      end
    end
  end

  // Outstanding-store vector
  always_comb begin
    pendingNext = pending;
    if (issueValid) pendingNext[issueSlot] = 1'b0;
    if (dispValid)  pendingNext[dispSlot]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pending <= '0;
    else if (clearReq) pending <= '0;
    else               pending <= pendingNext;
  end

  // Lookup, registered, from pre-update state
  logic                lkHit;
  logic [ID_W-1:0]     lkId;
  logic                lkStrict;
  logic [SQ_SLOTS-1:0] lkMask;
  assign lkHit = ssitValid[lookIdx];
  assign lkId  = ssitId[lookIdx];

  always_comb begin
    lkStrict = 1'b0;
    lkMask   = '0;
    if (strictEnable && lkHit && ssitStrict[lookIdx]) begin
      lkStrict = 1'b1;
      lkMask   = pending;
    end else if (lkHit && lfstValid[lkId]) begin
      lkMask = {{(SQ_SLOTS-1){1'b0}}, 1'b1} << lfstSlot[lkId];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depValid  <= 1'b0;
      depStrict <= 1'b0;
      depMask   <= '0;
    end else begin
      depValid  <= lookupValid;
      depStrict <= lookupValid && lkStrict;
      depMask   <= lookupValid ? lkMask : '0;
    end
  end

  // R6: a dispatch leaves its slot pending
  p_disp_sets_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !clearReq) |=> pending[$past(dispSlot)]);

  // R7: an issue (without a same-slot dispatch) removes its slot
  p_issue_clears_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !clearReq && !(dispValid && dispSlot == issueSlot))
      |=> !pending[$past(issueSlot)]);

  // R10: clear empties every structure
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (pending == '0 && lfstValid == '0 && ssitValid == '0));

  // R8: a non-strict result names at most one slot
  p_normal_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (depValid && !depStrict) |-> $onehot0(depMask));

  // R9: strict results only appear when the feature was enabled
  p_strict_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (depValid && depStrict) |-> $past(strictEnable));

  // R2: idle outputs are quiet
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !depValid |-> (depMask == '0 && !depStrict));

endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
  import ssp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SSIT_DEPTH = 64,
  parameter int NUM_SETS   = 16,
  parameter int SQ_SLOTS   = 16,
  localparam int ID_W      = $clog2(NUM_SETS),
  localparam int SLOT_W    = $clog2(SQ_SLOTS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strictEnable,
  input  logic                clearReq,
  input  logic                trainValid,
  input  logic [PC_W-1:0]     trainLoadPc,
  input  logic [PC_W-1:0]     trainStorePc,
  input  logic                dispValid,
  input  logic [PC_W-1:0]     dispPc,
  input  logic [SLOT_W-1:0]   dispSlot,
  input  logic                issueValid,
  input  logic [SLOT_W-1:0]   issueSlot,
  input  logic                lookupValid,
  input  logic [PC_W-1:0]     lookupPc,
  output logic                depValid,
  output logic                depStrict,
  output logic [SQ_SLOTS-1:0] depMask
);

  trainStrobe_t    strobe;
  logic            loadHit, storeHit;
  logic [ID_W-1:0] loadId, storeId;

  ssp_train_ctrl #(.ID_W(ID_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .clearReq   (clearReq),
    .trainValid (trainValid),
    .loadHit    (loadHit),
    .storeHit   (storeHit),
    .loadId     (loadId),
    .storeId    (storeId),
    .strobe     (strobe)
  );

  ssp_tables #(
    .PC_W       (PC_W),
    .SSIT_DEPTH (SSIT_DEPTH),
    .NUM_SETS   (NUM_SETS),
    .SQ_SLOTS   (SQ_SLOTS)
  ) tables_i (
    .clk          (clk),
    .rstN         (rstN),
    .strictEnable (strictEnable),
    .clearReq     (clearReq),
    .strobe       (strobe),
    .trainLoadPc  (trainLoadPc),
    .trainStorePc (trainStorePc),
    .dispValid    (dispValid),
    .dispPc       (dispPc),
    .dispSlot     (dispSlot),
    .issueValid   (issueValid),
    .issueSlot    (issueSlot),
    .lookupValid  (lookupValid),
    .lookupPc     (lookupPc),
    .loadHit      (loadHit),
    .storeHit     (storeHit),
    .loadId       (loadId),
    .storeId      (storeId),
    .depValid     (depValid),
    .depStrict    (depStrict),
    .depMask      (depMask)
  );

endmodule

// File: tb/ssp_predictor_tb.sv
module ssp_predictor_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        strictEnable, clearReq, trainValid, dispValid, issueValid, lookupValid;
  logic [31:0] trainLoadPc, trainStorePc, dispPc, lookupPc;
  logic [3:0]  dispSlot, issueSlot;
  logic        depValid, depStrict;
  logic [15:0] depMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_predictor dut_i (
    .clk(clk), .rstN(rstN), .strictEnable(strictEnable), .clearReq(clearReq),
    .trainValid(trainValid), .trainLoadPc(trainLoadPc), .trainStorePc(trainStorePc),
    .dispValid(dispValid), .dispPc(dispPc), .dispSlot(dispSlot),
    .issueValid(issueValid), .issueSlot(issueSlot),
    .lookupValid(lookupValid), .lookupPc(lookupPc),
    .depValid(depValid), .depStrict(depStrict), .depMask(depMask)
  );

  // Addresses: A idx16 (fresh id 0), C idx18 (fresh id 2), B/D/E stores
  localparam logic [7:0] PA = 8'h40, PB = 8'h84, PC = 8'h48, PD = 8'h8C, PE = 8'h90;

  typedef struct packed {
    logic       tr;  logic [7:0] trLd; logic [7:0] trSt;
    logic       dv;  logic [7:0] dPc;  logic [3:0] dSlot;
    logic       iv;  logic [3:0] iSlot;
    logic       lv;  logic [7:0] lPc;  logic en;
    logic       expV; logic expS; logic [15:0] expM;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b0,16'h0000}, // 0 R8 untrained
    '{1'b1,PA,PB,     1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b0,16'h0000}, // 1 R3 R2 old state
    '{1'b0,8'h0,8'h0, 1'b1,PB,4'd3,   1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b0,16'h0000}, // 2 R6 R2
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b0,16'h0008}, // 3 R8
    '{1'b0,8'h0,8'h0, 1'b1,PD,4'd5,   1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b0,16'h0008}, // 4 R6 untrained store
    '{1'b1,PA,PB,     1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b0,16'h0008}, // 5 R5 equal ids
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b1,16'h0028}, // 6 R9 strict
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b0, 1'b1,1'b0,16'h0008}, // 7 R9 disabled
    '{1'b0,8'h0,8'h0, 1'b1,PD,4'd7,   1'b1,4'd3, 1'b1,PA,1'b1, 1'b1,1'b1,16'h0028}, // 8 R7 dual
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b1,16'h00A0}, // 9 R7 R9
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b0, 1'b1,1'b0,16'h0000}, // 10 R7 record gone
    '{1'b1,PC,PD,     1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0000}, // 11 R3 fresh id 2
    '{1'b0,8'h0,8'h0, 1'b1,PD,4'd9,   1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0000}, // 12 R6
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0200}, // 13 R3 R8
    '{1'b1,PC,PB,     1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0200}, // 14 R5 load takes 0
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0000}, // 15 R5
    '{1'b1,PA,PD,     1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b1,16'h02A0}, // 16 R5 store takes 0
    '{1'b0,8'h0,8'h0, 1'b1,PD,4'd11,  1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0000}, // 17 R6
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0800}, // 18 R5 R8
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b1,4'd11, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0800}, // 19 R2 R7
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0000}, // 20 R7
    '{1'b1,PA,PE,     1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PA,1'b1, 1'b1,1'b1,16'h02A0}, // 21 R4 strict kept
    '{1'b0,8'h0,8'h0, 1'b1,PE,4'd1,   1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0000}, // 22 R4
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b1,PC,1'b1, 1'b1,1'b0,16'h0002}, // 23 R4 E in set 0
    '{1'b0,8'h0,8'h0, 1'b0,8'h0,4'd0, 1'b0,4'd0, 1'b0,8'h0,1'b1, 1'b0,1'b0,16'h0000}  // 24 R2 idle
  };

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  task automatic check(input string req, input logic v, input logic s, input logic [15:0] m,
                       input logic ev, input logic es, input logic [15:0] em);
    checks++;
    if (v !== ev || s !== es || m !== em) begin
      errors++;
      $display("FAIL %s: actual valid=%0b strict=%0b mask=%h expected valid=%0b strict=%0b mask=%h",
               req, v, s, m, ev, es, em);
    end
  endtask

  task automatic idle();
    clearReq = 0; trainValid = 0; dispValid = 0; issueValid = 0; lookupValid = 0;
    trainLoadPc = '0; trainStorePc = '0; dispPc = '0; lookupPc = '0;
    dispSlot = '0; issueSlot = '0; strictEnable = 1'b1;
  endtask

  task automatic apply(input vec_t v);
    trainValid = v.tr; trainLoadPc = {24'h0, v.trLd}; trainStorePc = {24'h0, v.trSt};
    dispValid = v.dv; dispPc = {24'h0, v.dPc}; dispSlot = v.dSlot;
    issueValid = v.iv; issueSlot = v.iSlot;
    lookupValid = v.lv; lookupPc = {24'h0, v.lPc}; strictEnable = v.en;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic vec_t mk(input logic tr, input logic [7:0] ld, input logic [7:0] st,
                              input logic dv, input logic [7:0] dp, input logic [3:0] ds,
                              input logic lv, input logic [7:0] lp);
    vec_t v;
    v = '0;
    v.tr = tr; v.trLd = ld; v.trSt = st; v.dv = dv; v.dPc = dp; v.dSlot = ds;
    v.lv = lv; v.lPc = lp; v.en = 1'b1;
    return v;
  endfunction

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", depValid, depStrict, depMask, 1'b0, 1'b0, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    // R1: an untrained lookup with nothing pending returns zero
    apply(mk(0, 0, 0, 0, 0, 0, 1, PA));
    check("R1 empty tables", depValid, depStrict, depMask, 1'b1, 1'b0, 16'h0000);

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k]);
      check($sformatf("R2/R3-R9 vector %0d", k), depValid, depStrict, depMask,
            VEC[k].expV, VEC[k].expS, VEC[k].expM);
    end

    // R10: clear wipes tables, strict bits and the pending vector
    clearReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    idle();
    apply(mk(0, 0, 0, 0, 0, 0, 1, PA));
    check("R10 tables cleared", depValid, depStrict, depMask, 1'b1, 1'b0, 16'h0000);
    apply(mk(1, PA, PB, 0, 0, 0, 0, 0));
    apply(mk(0, 0, 0, 0, 0, 0, 1, PA));
    check("R3 fresh set after clear not strict", depValid, depStrict, depMask, 1'b1, 1'b0, 16'h0000);
    apply(mk(1, PA, PB, 0, 0, 0, 0, 0));
    apply(mk(0, 0, 0, 0, 0, 0, 1, PA));
    check("R10 pending emptied, R9 strict", depValid, depStrict, depMask, 1'b1, 1'b1, 16'h0000);
    apply(mk(0, 0, 0, 1, PB, 4'd4, 0, 0));
    apply(mk(0, 0, 0, 0, 0, 0, 1, PA));
    check("R9 strict sees new pending", depValid, depStrict, depMask, 1'b1, 1'b1, 16'h0010);
    // R2: lookup result drops after the lookup is removed
    @(posedge clk);
    @(negedge clk);
    check("R2 no lookup", depValid, depStrict, depMask, 1'b0, 1'b0, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule